// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a segmented logical address into a linear address. A request carries a 16-bit selector and an offset. The selector picks one descriptor out of two on-chip descriptor tables: a global table shared by all processes and a local table that belongs to the running process. Each descriptor holds a base, a limit, a privilege level and a valid flag. The block checks the offset against the limit and the requested privilege against the descriptor's level. If every check passes, it returns base plus offset. If a check fails, it returns a fault code and no address.

Requests and responses each use a valid/ready handshake. An accepted request produces a registered response one cycle later. The response register holds one entry, so a stalled consumer stalls the requester. Software fills the tables through a write port. That port acts only when the write is marked as coming from kernel mode. Each table holds `DEPTH` descriptors, up to the 8K that the 13-bit index can address.

Top module: `segx_xlate`

## Requirements
- R1: The selector is decoded as bits [15:3] = descriptor index, bit [2] = table choice (0 global, 1 local), bits [1:0] = requested privilege.
- R2: With no fault, the response address equals descriptor base plus offset, modulo 2^ADDR_W.
- R3: An offset equal to the limit is accepted. An offset greater than the limit gives fault code 2 (limit).
- R4: A descriptor whose valid flag is clear, or an index at or beyond DEPTH, gives fault code 1 (invalid).
- R5: A requested privilege numerically greater than the descriptor's level gives fault code 3 (privilege). Equal or smaller is allowed.
- R6: When several checks fail, the code reported is invalid first, then privilege, then limit. Code 0 means no fault.
- R7: Any faulting response carries address zero.
- R8: A table write takes effect only when wr_kern is 1 and wr_idx is below DEPTH. Any other write leaves every descriptor unchanged.
- R9: A request is accepted when req_valid and req_ready are both high, and rsp_valid is high in the next cycle. While rsp_valid is high and rsp_ready is low, the response stays unchanged and req_ready is low.
- R10: After reset, rsp_valid is low, req_ready is high and every descriptor is invalid.
- R11: A request accepted in the same cycle as a write to its descriptor sees the contents from before that write.
- R12: The two tables are independent. A write to one table at an index leaves the other table's entry at that index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 16 | Segment selector |
| req_off | input | ADDR_W | Offset within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | ADDR_W | Linear address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 limit, 3 privilege |
| wr_en | input | 1 | Descriptor write strobe |
| wr_kern | input | 1 | Write comes from kernel mode |
| wr_local | input | 1 | Write targets the local table (0 global) |
| wr_idx | input | 13 | Descriptor index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_dpl | input | 2 | Descriptor privilege level to store |
| wr_base | input | ADDR_W | Segment base to store |
| wr_limit | input | ADDR_W | Highest legal offset to store |

## Verification
The bench sends offsets at exactly the limit and one past it. A design with the comparison off by one would either fault a legal last byte or pass the first illegal one. It builds requests that fail several checks at once, so a wrong priority order shows up as the wrong fault code. It issues user-mode writes, writes to out-of-range indices, and a write in the same cycle as a request to the same descriptor. This catches a protection gate that leaks and a table read that picks up new contents too early. A base near the top of the address space checks wraparound. A stalled consumer checks that the held response does not change and that no request slips past it.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int PRIV_W = 2;

    // Field positions inside the selector; the decode depends on them.
    localparam int SEL_IDX_LSB = 3;
    localparam int SEL_TBL_BIT = 2;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_LIMIT   = 2'd2,
        FLT_PRIV    = 2'd3
    } fault_e;

endpackage

// File: rtl/segx_table.sv
module segx_table #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_kern,
    input  logic [segx_pkg::IDX_W-1:0]    wr_idx,
    input  logic                          wr_valid,
    input  logic [segx_pkg::PRIV_W-1:0]   wr_dpl,
    input  logic [ADDR_W-1:0]             wr_base,
    input  logic [ADDR_W-1:0]             wr_limit,
    input  logic [segx_pkg::IDX_W-1:0]    rd_idx,
    output logic                          rd_valid,
    output logic [segx_pkg::PRIV_W-1:0]   rd_dpl,
    output logic [ADDR_W-1:0]             rd_base,
    output logic [ADDR_W-1:0]             rd_limit
);
    import segx_pkg::*;

    localparam int LW = $clog2(DEPTH);

    typedef struct packed {
        logic              valid;
        logic [PRIV_W-1:0] dpl;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } entry_t;

    entry_t mem_d [DEPTH];
    entry_t mem_q [DEPTH];

    logic wr_hit;
    logic rd_in_range;
    entry_t rd_ent;

    assign wr_hit      = wr_en && wr_kern && ({1'b0, wr_idx} < (IDX_W+1)'(DEPTH));
    assign rd_in_range = {1'b0, rd_idx} < (IDX_W+1)'(DEPTH);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_hit) begin
            mem_d[wr_idx[LW-1:0]] = '{valid: wr_valid, dpl: wr_dpl,
                                      base: wr_base, limit: wr_limit};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rd_ent   = mem_q[rd_idx[LW-1:0]];
        rd_valid = rd_in_range && rd_ent.valid;
        rd_dpl   = rd_ent.dpl;
        rd_base  = rd_ent.base;
        rd_limit = rd_ent.limit;
    end

    // R8: an entry only changes under a privileged, in-range write to it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_guard
        p_kern_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_kern && wr_idx == IDX_W'(g)) |=> $stable(mem_q[g]));
    end

endmodule

// File: rtl/segx_check.sv
module segx_check #(
    parameter int ADDR_W = 32
) (
    input  logic [segx_pkg::PRIV_W-1:0] rpl,
    input  logic                        desc_valid,
    input  logic [segx_pkg::PRIV_W-1:0] dpl,
    input  logic [ADDR_W-1:0]           base,
    input  logic [ADDR_W-1:0]           limit,
    input  logic [ADDR_W-1:0]           off,
    output segx_pkg::fault_e            fault,
    output logic [ADDR_W-1:0]           addr
);
    import segx_pkg::*;

    logic priv_bad;
    logic over_lim;

    assign priv_bad = rpl > dpl;
    assign over_lim = off > limit;

    always_comb begin
        if (!desc_valid) begin
            fault = FLT_INVALID;
        end else if (priv_bad) begin
            fault = FLT_PRIV;
        end else if (over_lim) begin
            fault = FLT_LIMIT;
        end else begin
            fault = FLT_NONE;
        end
        addr = (fault == FLT_NONE) ? base + off : '0;
    end

endmodule

// File: rtl/segx_xlate.sv
module segx_xlate #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_sel,
    input  logic [ADDR_W-1:0] req_off,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_fault,
    input  logic              wr_en,
    input  logic              wr_kern,
    input  logic              wr_local,
    input  logic [12:0]       wr_idx,
    input  logic              wr_valid,
    input  logic [1:0]        wr_dpl,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit
);
    import segx_pkg::*;

    localparam int NTBL = 2;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        fault_e            fault;
    } rsp_t;

    rsp_t st_d, st_q;

    logic [IDX_W-1:0]  sel_idx;
    logic              sel_tbl;
    logic [PRIV_W-1:0] sel_rpl;

    assign sel_idx = req_sel[SEL_W-1:SEL_IDX_LSB];
    assign sel_tbl = req_sel[SEL_TBL_BIT];
    assign sel_rpl = req_sel[PRIV_W-1:0];

    logic              t_valid [NTBL];
    logic [PRIV_W-1:0] t_dpl   [NTBL];
    logic [ADDR_W-1:0] t_base  [NTBL];
    logic [ADDR_W-1:0] t_limit [NTBL];

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        segx_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_local == 1'(t))),
            .wr_kern  (wr_kern),
            .wr_idx   (wr_idx),
            .wr_valid (wr_valid),
            .wr_dpl   (wr_dpl),
            .wr_base  (wr_base),
            .wr_limit (wr_limit),
            .rd_idx   (sel_idx),
            .rd_valid (t_valid[t]),
            .rd_dpl   (t_dpl[t]),
            .rd_base  (t_base[t]),
            .rd_limit (t_limit[t])
        );
    end

    fault_e            chk_fault;
    logic [ADDR_W-1:0] chk_addr;

    segx_check #(.ADDR_W(ADDR_W)) u_chk (
        .rpl        (sel_rpl),
        .desc_valid (t_valid[sel_tbl]),
        .dpl        (t_dpl[sel_tbl]),
        .base       (t_base[sel_tbl]),
        .limit      (t_limit[sel_tbl]),
        .off        (req_off),
        .fault      (chk_fault),
        .addr       (chk_addr)
    );

    assign req_ready = !st_q.valid || rsp_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && rsp_ready) begin
            st_d.valid = 1'b0;
        end
        if (req_valid && req_ready) begin
            st_d.valid = 1'b1;
            st_d.addr  = chk_addr;
            st_d.fault = chk_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, addr: '0, fault: FLT_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_addr  = st_q.addr;
    assign rsp_fault = st_q.fault;

    // R7: a refused access never shows an address.
    p_fault_noaddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_addr == '0);

    // R9: accepted request yields a response next cycle.
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R9: held response does not move while stalled.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    // R9: nothing enters while the response register is blocked.
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

// File: tb/segx_xlate_tb.sv
module segx_xlate_tb;

    localparam int AW = 32;
    localparam int D  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, rsp_valid, rsp_ready;
    logic [15:0]   req_sel;
    logic [AW-1:0] req_off, rsp_addr;
    logic [1:0]    rsp_fault;
    logic          wr_en, wr_kern, wr_local, wr_valid;
    logic [12:0]   wr_idx;
    logic [1:0]    wr_dpl;
    logic [AW-1:0] wr_base, wr_limit;

    always #5 clk = ~clk;

    segx_xlate #(.ADDR_W(AW), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .wr_en(wr_en), .wr_kern(wr_kern), .wr_local(wr_local),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dpl(wr_dpl),
        .wr_base(wr_base), .wr_limit(wr_limit)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R10";
    bit    done = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Behavioural reference: descriptor storage plus one pending response.
    logic          m_v    [2][D];
    logic [1:0]    m_dpl  [2][D];
    logic [AW-1:0] m_base [2][D];
    logic [AW-1:0] m_lim  [2][D];
    logic          e_valid;
    logic [AW-1:0] e_addr;
    logic [1:0]    e_fault;

    function automatic logic [1:0] ref_fault(input logic [15:0] sel, input logic [AW-1:0] off);
        int t   = int'(sel[2]);
        int idx = int'(sel[15:3]);
        if (idx >= D) return 2'd1;
        if (!m_v[t][idx]) return 2'd1;
        if (sel[1:0] > m_dpl[t][idx]) return 2'd3;
        if (off > m_lim[t][idx]) return 2'd2;
        return 2'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 1'b0;
            for (int t = 0; t < 2; t++)
                for (int i = 0; i < D; i++) begin
                    m_v[t][i] <= 1'b0; m_dpl[t][i] <= '0;
                    m_base[t][i] <= '0; m_lim[t][i] <= '0;
                end
        end else begin
            if (e_valid && rsp_ready) e_valid <= 1'b0;
            if (req_valid && (!e_valid || rsp_ready)) begin
                e_valid <= 1'b1;
                e_fault <= ref_fault(req_sel, req_off);
                e_addr  <= (ref_fault(req_sel, req_off) == 2'd0)
                           ? m_base[int'(req_sel[2])][int'(req_sel[15:3])] + req_off : '0;
            end
            if (wr_en && wr_kern && int'(wr_idx) < D) begin
                m_v[int'(wr_local)][int'(wr_idx)]    <= wr_valid;
                m_dpl[int'(wr_local)][int'(wr_idx)]  <= wr_dpl;
                m_base[int'(wr_local)][int'(wr_idx)] <= wr_base;
                m_lim[int'(wr_local)][int'(wr_idx)]  <= wr_limit;
            end
        end
    end

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(rsp_valid == e_valid, "model rsp_valid", 32'(rsp_valid), 32'(e_valid));
            chk(req_ready == (!e_valid || rsp_ready), "model req_ready",
                32'(req_ready), 32'(!e_valid || rsp_ready));
            if (e_valid) begin
                chk(rsp_fault == e_fault, "model fault", 32'(rsp_fault), 32'(e_fault));
                chk(rsp_addr == e_addr, "model addr", rsp_addr, e_addr);
            end
        end
    end

    function automatic logic [15:0] mksel(input int idx, input bit loc, input int rpl);
        return {13'(idx), loc, 2'(rpl)};
    endfunction

    task automatic wr(input bit kern, input bit loc, input int idx, input bit v,
                      input int dpl, input logic [AW-1:0] base, input logic [AW-1:0] lim);
        @(negedge clk);
        wr_en = 1; wr_kern = kern; wr_local = loc; wr_idx = 13'(idx);
        wr_valid = v; wr_dpl = 2'(dpl); wr_base = base; wr_limit = lim;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Directed request with a fixed expected outcome; consumer always ready.
    task automatic xreq(input logic [15:0] sel, input logic [AW-1:0] off,
                        input int exp_f, input logic [AW-1:0] exp_a);
        @(negedge clk);
        req_valid = 1; req_sel = sel; req_off = off;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, "response present", 32'(rsp_valid), 32'd1);
        chk(rsp_fault == 2'(exp_f), "fault code", 32'(rsp_fault), 32'(exp_f));
        chk(rsp_addr == exp_a, "address", rsp_addr, exp_a);
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_sel = '0; req_off = '0; rsp_ready = 1;
        wr_en = 0; wr_kern = 0; wr_local = 0; wr_idx = '0; wr_valid = 0;
        wr_dpl = '0; wr_base = '0; wr_limit = '0;
        repeat (3) @(negedge clk);
        cur_req = "R10";
        chk(rsp_valid == 1'b0, "reset rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "reset req_ready", 32'(req_ready), 32'd1);
        xreq(mksel(0, 0, 0), 32'h0, 1, 32'h0);
        xreq(mksel(0, 1, 0), 32'h0, 1, 32'h0);

        cur_req = "R8";
        wr(0, 0, 1, 1, 2, 32'h1000, 32'hFF);
        xreq(mksel(1, 0, 0), 32'h10, 1, 32'h0);
        wr(1, 0, 20, 1, 3, 32'h5000, 32'hFFFF);
        cur_req = "R4";
        xreq(mksel(20, 0, 0), 32'h0, 1, 32'h0);
        wr(1, 0, 15, 1, 3, 32'h7000, 32'h40);
        xreq(mksel(15, 0, 1), 32'h40, 0, 32'h7040);
        wr(1, 0, 15, 0, 3, 32'h7000, 32'h40);
        xreq(mksel(15, 0, 0), 32'h0, 1, 32'h0);

        cur_req = "R3";
        wr(1, 0, 1, 1, 2, 32'h1000, 32'hFF);
        xreq(mksel(1, 0, 2), 32'hFF, 0, 32'h10FF);
        xreq(mksel(1, 0, 2), 32'h100, 2, 32'h0);
        cur_req = "R7";
        xreq(mksel(1, 0, 0), 32'hFFFF_0000, 2, 32'h0);
        cur_req = "R5";
        xreq(mksel(1, 0, 3), 32'h0, 3, 32'h0);
        xreq(mksel(1, 0, 1), 32'h4, 0, 32'h1004);
        cur_req = "R6";
        xreq(mksel(1, 0, 3), 32'h100, 3, 32'h0);
        xreq(mksel(2, 0, 3), 32'h100, 1, 32'h0);

        cur_req = "R12";
        wr(1, 1, 1, 1, 0, 32'h2000, 32'h10);
        xreq(mksel(1, 0, 0), 32'h5, 0, 32'h1005);
        cur_req = "R1";
        xreq(16'h000C, 32'h5, 0, 32'h2005);
        xreq(16'h000D, 32'h5, 3, 32'h0);

        cur_req = "R2";
        wr(1, 0, 3, 1, 3, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
        xreq(mksel(3, 0, 3), 32'h20, 0, 32'h10);
        xreq(mksel(3, 0, 0), 32'hFFFF_FFFF, 0, 32'hFFFF_FFEF);

        cur_req = "R11";
        @(negedge clk);
        wr_en = 1; wr_kern = 1; wr_local = 0; wr_idx = 13'd4; wr_valid = 1;
        wr_dpl = 2'd3; wr_base = 32'h3000; wr_limit = 32'hF;
        req_valid = 1; req_sel = mksel(4, 0, 0); req_off = 32'h1;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        chk(rsp_fault == 2'd1, "same-cycle write not seen", 32'(rsp_fault), 32'd1);
        xreq(mksel(4, 0, 0), 32'h1, 0, 32'h3001);

        cur_req = "R9";
        @(negedge clk);
        rsp_ready = 0; req_valid = 1; req_sel = mksel(4, 0, 0); req_off = 32'h2;
        @(negedge clk);
        req_sel = mksel(1, 0, 0); req_off = 32'h3;
        for (int k = 0; k < 3; k++) begin
            chk(rsp_valid && rsp_addr == 32'h3002, "held response",
                rsp_addr, 32'h3002);
            chk(req_ready == 1'b0, "stalled ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        rsp_ready = 1;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid && rsp_addr == 32'h1003, "queued request after release",
            rsp_addr, 32'h1003);
        repeat (3) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule